// File: doc/BRIEF.md
# Serial Bit-Stream Memory Request Responder

This block terminates a one-bit serial request link and turns each incoming frame into a parallel access on a local memory port. Every serial word is framed only by a one-cycle pulse on the incoming valid line on its first bit. The word then arrives least significant bit first, one bit per clock. The responder assembles a header word and splits it into an opcode, a reserved field and a physical address. The opcode tells it whether a second word carrying write data must follow.

When a request is complete, the block raises a request strobe with the address, direction and write data. It holds the strobe until the memory port accepts it, then waits for the port's response pulse. It answers a write with a single return-valid pulse. It answers a read with a return-valid pulse followed by the read value, sent serially LSB first. Malformed or unknown headers and broken write framing are dropped and raise a sticky error flag.

Top module: `bitlink_mem_responder`

## Requirements
- R1: A word starts on a cycle where `rx_vld` is 1 while the block waits for a header, and it is taken from `rx_dat` over WORD_W (64) consecutive cycles, bit 0 first.
- R2: Header layout: the opcode sits in bits 63:56, a reserved field in bits 55:40 and the address in bits 39:0. Opcode 0x81 with a zero reserved field issues a request with `mem_we`=0 and `mem_addr` equal to header bits 39:0.
- R3: Opcode 0x82 with a zero reserved field is a write. Its data word must start with an `rx_vld` pulse on the cycle right after the header's last bit. The request then carries `mem_we`=1 and `mem_wdata` equal to the data word.
- R4: `mem_req` stays 1, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until a cycle where `mem_rdy` is 1. The block then waits for `mem_rsp_vld`.
- R5: A write is answered on the cycle after the `mem_rsp_vld` cycle by `tx_vld`=1 for exactly one cycle, and no data bits follow.
- R6: A read is answered on the cycle after the `mem_rsp_vld` cycle by a one-cycle `tx_vld`. On the following WORD_W cycles `tx_dat` carries the `mem_rdata` value captured with `mem_rsp_vld`, bit 0 first.
- R7: `tx_dat` is 0 on every cycle that is not one of the read-data cycles of R6, including the `tx_vld` cycle.
- R8: `tx_vld` is never 1 during the two cycles that follow the last bit of a request.
- R9: A header whose opcode is neither 0x81 nor 0x82, or whose reserved field is nonzero, produces no memory request and no response, and it sets `err_flag`. `err_flag` stays 1 until reset.
- R10: A write header not followed at once by a data-word `rx_vld` pulse is aborted without a memory request or response, and it sets `err_flag`.
- R11: `rx_vld` pulses that arrive while a request is being served or answered start no word, and they cause no extra request or response.
- R12: A synchronous active-low `rst_n` clears `err_flag`, drops `mem_req`, `tx_vld` and `tx_dat` to 0, abandons any partial word, and returns the block to waiting for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_vld | input | 1 | Serial request frame pulse on the first bit of a word |
| rx_dat | input | 1 | Serial request data, LSB first |
| tx_vld | output | 1 | One-cycle response pulse |
| tx_dat | output | 1 | Serial read data, LSB first; 0 when idle |
| mem_req | output | 1 | Memory request strobe, held until accepted |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | WORD_W | Write data |
| mem_rdy | input | 1 | Memory port accepts the request |
| mem_rsp_vld | input | 1 | Memory port completion pulse |
| mem_rdata | input | WORD_W | Read data, valid with mem_rsp_vld |
| err_flag | output | 1 | Sticky error for dropped or aborted requests |

## Verification
The bench builds the block with its default parameters: 64-bit words, an 8-bit opcode, a 40-bit address and a 16-bit reserved field. With these values the reserved-field check branch is present, so nonzero bits at both ends of that field can be shown to drop a header. Addresses that reach bit 39 and data words with bit 63 set travel the whole serial path in both directions. The memory port is stalled for several cycles to show the request is held, and a second request frame is injected while a read is being returned.

// File: rtl/blmr_pkg.sv
package blmr_pkg;

   // responder sequencing states
   typedef enum logic [2:0] {
      ST_RX   = 3'd0,   // waiting for / receiving header
      ST_WDAT = 3'd1,   // receiving write data word
      ST_MREQ = 3'd2,   // request strobe asserted
      ST_MRSP = 3'd3,   // waiting for memory completion
      ST_RESP = 3'd4,   // return valid pulse
      ST_SEND = 3'd5    // serial read data out
   } blmr_state_e;

endpackage

// File: rtl/blmr_deser.sv
module blmr_deser #(
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              vld,
   input  logic              dat,
   output logic [WORD_W-1:0] word,
   output logic              done,
   output logic              busy
);
   localparam int CW = $clog2(WORD_W);
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   logic [WORD_W-1:0] sr;
   logic [CW-1:0]     cnt;
   logic              active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr     <= '0;
         cnt    <= '0;
         active <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= active && (cnt == LAST);
         if (!active) begin
            if (accept && vld) begin
               sr     <= {dat, sr[WORD_W-1:1]};
               cnt    <= CW'(1);
               active <= 1'b1;
            end
         end else begin
            sr <= {dat, sr[WORD_W-1:1]};
            if (cnt == LAST) begin
               cnt    <= '0;
               active <= 1'b0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   assign word = sr;
   assign busy = active;

   // a completed word is never followed by another completion next cycle
   assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/blmr_ser.sv
module blmr_ser #(
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_data,
   input  logic              start,
   output logic              bit_o,
   output logic              last
);
   localparam int CW = $clog2(WORD_W);
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   logic [WORD_W-1:0] sr;
   logic [CW-1:0]     cnt;
   logic              active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr     <= '0;
         cnt    <= '0;
         active <= 1'b0;
      end else if (load) begin
         sr <= load_data;
      end else if (start) begin
         cnt    <= '0;
         active <= 1'b1;
      end else if (active) begin
         sr <= {1'b0, sr[WORD_W-1:1]};
         if (cnt == LAST) begin
            active <= 1'b0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   assign bit_o = active & sr[0];
   assign last  = active && (cnt == LAST);

   // a new read return never begins while one is still shifting
   assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !active);

endmodule

// File: rtl/bitlink_mem_responder.sv
module bitlink_mem_responder #(
   parameter int             WORD_W   = 64,
   parameter int             OP_W     = 8,
   parameter int             ADDR_W   = 40,
   parameter logic [OP_W-1:0] OP_READ  = 8'h81,
   parameter logic [OP_W-1:0] OP_WRITE = 8'h82
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_vld,
   input  logic              rx_dat,
   output logic              tx_vld,
   output logic              tx_dat,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_rdy,
   input  logic              mem_rsp_vld,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              err_flag
);
   import blmr_pkg::*;

   localparam int RSV_W = WORD_W - OP_W - ADDR_W;

   // elaboration-time parameter checks
   if (WORD_W < 4) begin : g_bad_word
      $error("WORD_W must be at least 4");
   end
   if (RSV_W < 0) begin : g_bad_split
      $error("OP_W + ADDR_W exceeds WORD_W");
   end
   if (OP_READ == OP_WRITE) begin : g_bad_ops
      $error("read and write opcodes must differ");
   end

   blmr_state_e       st;
   logic [WORD_W-1:0] rx_word;
   logic              rx_done;
   logic              rx_busy;
   logic              rx_accept;
   logic [ADDR_W-1:0] addr_q;
   logic              we_q;
   logic              ser_bit;
   logic              ser_last;
   logic              rsv_ok;
   logic [OP_W-1:0]   hdr_op;
   logic              hdr_rd;
   logic              hdr_wr;

   assign hdr_op = rx_word[WORD_W-1 -: OP_W];

   // reserved-field check exists only when the split leaves reserved bits
   if (RSV_W > 0) begin : g_rsv_chk
      assign rsv_ok = (rx_word[ADDR_W +: RSV_W] == '0);
   end else begin : g_rsv_none
      assign rsv_ok = 1'b1;
   end

   assign hdr_rd = rsv_ok && (hdr_op == OP_READ);
   assign hdr_wr = rsv_ok && (hdr_op == OP_WRITE);

   // new frames are taken only while waiting for a header, except on the
   // completion cycle of a read header
   assign rx_accept = (st == ST_RX) && !(rx_done && hdr_rd);

   blmr_deser #(.WORD_W(WORD_W)) u_deser (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (rx_accept),
      .vld    (rx_vld),
      .dat    (rx_dat),
      .word   (rx_word),
      .done   (rx_done),
      .busy   (rx_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_RX;
         addr_q   <= '0;
         we_q     <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         case (st)
            ST_RX: begin
               if (rx_done) begin
                  if (hdr_rd) begin
                     addr_q <= rx_word[ADDR_W-1:0];
                     we_q   <= 1'b0;
                     st     <= ST_MREQ;
                  end else if (hdr_wr && rx_vld) begin
                     addr_q <= rx_word[ADDR_W-1:0];
                     we_q   <= 1'b1;
                     st     <= ST_WDAT;
                  end else begin
                     err_flag <= 1'b1;
                  end
               end
            end
            ST_WDAT: if (rx_done) st <= ST_MREQ;
            ST_MREQ: if (mem_rdy) st <= ST_MRSP;
            ST_MRSP: if (mem_rsp_vld) st <= ST_RESP;
            ST_RESP: st <= we_q ? ST_RX : ST_SEND;
            ST_SEND: if (ser_last) st <= ST_RX;
            default: st <= ST_RX;
         endcase
      end
   end

   blmr_ser #(.WORD_W(WORD_W)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      ((st == ST_MRSP) && mem_rsp_vld && !we_q),
      .load_data (mem_rdata),
      .start     ((st == ST_RESP) && !we_q),
      .bit_o     (ser_bit),
      .last      (ser_last)
   );

   assign mem_req   = (st == ST_MREQ);
   assign mem_we    = we_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = rx_word;
   assign tx_vld    = (st == ST_RESP);
   assign tx_dat    = ser_bit;

   // request held with stable fields until the port accepts it
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   // response pulse is a single cycle
   assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_vld |=> !tx_vld);

   // data line idle on the response pulse cycle
   assert_vld_dat_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_vld |-> !tx_dat);

   // no response in the two cycles after a request's last bit
   assert_gap_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> !tx_vld);
   assert_gap_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !tx_vld);

   // error flag is sticky
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // broken write framing aborts back to header wait with error
   assert_wr_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_RX) && rx_done && hdr_wr && !rx_vld) |=> (err_flag && !mem_req));

   // the receiver stays idle while a request is served or answered
   assert_rx_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st inside {ST_MREQ, ST_MRSP, ST_RESP, ST_SEND}) |-> !rx_busy);

endmodule

// File: tb/sim_bitlink_mem_responder.sv
module sim_bitlink_mem_responder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_vld = 1'b0;
   logic        rx_dat = 1'b0;
   logic        tx_vld;
   logic        tx_dat;
   logic        mem_req;
   logic        mem_we;
   logic [39:0] mem_addr;
   logic [63:0] mem_wdata;
   logic        mem_rdy = 1'b1;
   logic        mem_rsp_vld = 1'b0;
   logic [63:0] mem_rdata;
   logic        err_flag;

   logic [63:0] rd_value = '0;

   always #2 clk = ~clk;   // 250 MHz

   bitlink_mem_responder u0 (
      .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_dat(rx_dat),
      .tx_vld(tx_vld), .tx_dat(tx_dat), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
      .mem_rsp_vld(mem_rsp_vld), .mem_rdata(mem_rdata), .err_flag(err_flag)
   );

   assign mem_rdata = rd_value;

   // memory port model: one-cycle completion after acceptance
   int          acc_cnt = 0;
   logic [39:0] cap_addr = '0;
   logic        cap_we = 1'b0;
   logic [63:0] cap_wdata = '0;
   always @(posedge clk) begin
      mem_rsp_vld <= mem_req && mem_rdy;
      if (mem_req && mem_rdy) begin
         acc_cnt   <= acc_cnt + 1;
         cap_addr  <= mem_addr;
         cap_we    <= mem_we;
         cap_wdata <= mem_wdata;
      end
   end

   // response monitor
   int          cyc = 0;
   int          vld_cnt = 0;
   int          vld_cyc = 0;
   int          rsp_cyc = 0;
   int          last_req_cyc = 0;
   int          rxcnt = 0;
   int          col_n = 0;
   int          stray = 0;
   logic        expect_read = 1'b0;
   logic [63:0] collected = '0;
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (rx_vld) rxcnt = 1;
      else if (rxcnt != 0) rxcnt = rxcnt + 1;
      if (rxcnt == 64) begin
         last_req_cyc = cyc;
         rxcnt = 0;
      end
      if (mem_rsp_vld) rsp_cyc = cyc;
      if (col_n > 0) begin
         collected = {tx_dat, collected[63:1]};
         col_n = col_n - 1;
      end else if (tx_dat) begin
         stray = stray + 1;
      end
      if (tx_vld) begin
         vld_cnt = vld_cnt + 1;
         vld_cyc = cyc;
         if (tx_dat) stray = stray + 1;
         if (expect_read) col_n = 64;
      end
   end

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_word(input logic [63:0] w);
      for (int i = 0; i < 64; i++) begin
         rx_vld = (i == 0);
         rx_dat = w[i];
         @(posedge clk); #1;
      end
      rx_vld = 1'b0;
      rx_dat = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // opcode, reserved, address, data / read value
   localparam logic [127:0] VEC [0:6] = '{
      {8'h81, 16'h0000, 40'h12_3456_789A, 64'hDEAD_BEEF_0BAD_F00D},
      {8'h82, 16'h0000, 40'hFF_0000_0008, 64'h0123_4567_89AB_CDEF},
      {8'h81, 16'h0000, 40'hFF_FFFF_FFF8, 64'h8000_0000_0000_0001},
      {8'h82, 16'h0000, 40'h00_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},
      {8'h83, 16'h0000, 40'h00_0000_0100, 64'h0},
      {8'h81, 16'h0001, 40'h00_0000_0200, 64'h0},
      {8'h82, 16'h8000, 40'h00_0000_0300, 64'h0}
   };

   initial begin
      logic exp_err;
      int   a0, v0;

      // reset state, R12
      idle(3);
      chk(!tx_vld && !tx_dat && !mem_req && !err_flag, "R12 reset outputs",
          {tx_vld, tx_dat, mem_req, err_flag}, 0);
      rst_n = 1'b1;
      idle(2);
      exp_err = 1'b0;

      // vector table walk, R1 R2 R3 R5 R6 R8 R9
      for (int k = 0; k < 7; k++) begin
         logic [7:0]  op;
         logic [15:0] rsv;
         logic [39:0] ad;
         logic [63:0] dw;
         logic        good_rd, good_wr;
         {op, rsv, ad, dw} = VEC[k];
         good_rd = (rsv == 0) && (op == 8'h81);
         good_wr = (rsv == 0) && (op == 8'h82);
         a0 = acc_cnt;
         v0 = vld_cnt;
         rd_value = dw;
         expect_read = good_rd;
         send_word({op, rsv, ad});
         if (good_wr) send_word(dw);
         idle(80);
         if (good_rd || good_wr) begin
            chk(acc_cnt == a0 + 1, "R2 one request", acc_cnt - a0, 1);
            chk(cap_addr == ad, "R2 address", cap_addr, ad);
            chk(cap_we == good_wr, "R2 direction", cap_we, good_wr);
            chk(vld_cnt == v0 + 1, "R5 one response", vld_cnt - v0, 1);
            chk(vld_cyc - rsp_cyc == 1, "R5 response timing", vld_cyc - rsp_cyc, 1);
            chk(vld_cyc - last_req_cyc >= 3, "R8 response gap",
                vld_cyc - last_req_cyc, 3);
            if (good_wr) chk(cap_wdata == dw, "R3 write data", cap_wdata, dw);
            else         chk(collected == dw, "R6 read data", collected, dw);
         end else begin
            exp_err = 1'b1;
            chk(acc_cnt == a0, "R9 no request", acc_cnt - a0, 0);
            chk(vld_cnt == v0, "R9 no response", vld_cnt - v0, 0);
         end
         chk(err_flag == exp_err, "R9 error flag", err_flag, exp_err);
      end

      // reset clears sticky error, R12
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
      chk(!err_flag, "R12 error cleared", err_flag, 0);

      // write data pulse one cycle late, R10
      a0 = acc_cnt;
      v0 = vld_cnt;
      expect_read = 1'b0;
      send_word({8'h82, 16'h0, 40'h00_0000_0400});
      idle(1);
      send_word(64'h0);
      idle(80);
      chk(acc_cnt == a0, "R10 no request", acc_cnt - a0, 0);
      chk(vld_cnt == v0, "R10 no response", vld_cnt - v0, 0);
      chk(err_flag, "R10 error flag", err_flag, 1);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);

      // memory port stall, R4
      mem_rdy = 1'b0;
      rd_value = 64'h5A5A_0F0F_1234_8765;
      expect_read = 1'b1;
      a0 = acc_cnt;
      send_word({8'h81, 16'h0, 40'hAB_CDEF_0010});
      idle(5);
      chk(mem_req, "R4 request raised", mem_req, 1);
      chk(mem_addr == 40'hAB_CDEF_0010, "R4 address held", mem_addr, 40'hAB_CDEF_0010);
      idle(4);
      chk(mem_req && mem_addr == 40'hAB_CDEF_0010 && !mem_we, "R4 still held",
          {mem_req, mem_we}, 2'b10);
      mem_rdy = 1'b1;
      idle(80);
      chk(acc_cnt == a0 + 1, "R4 accepted once", acc_cnt - a0, 1);
      chk(collected == 64'h5A5A_0F0F_1234_8765, "R4 read data", collected,
          64'h5A5A_0F0F_1234_8765);

      // new frame during read return is ignored, R11
      a0 = acc_cnt;
      v0 = vld_cnt;
      rd_value = 64'hC3C3_0000_FFFF_0001;
      send_word({8'h81, 16'h0, 40'h00_0000_0020});
      while (vld_cnt == v0) begin
         @(posedge clk); #1;
      end
      send_word({8'h81, 16'h0, 40'h00_0000_0040});
      idle(80);
      chk(acc_cnt == a0 + 1, "R11 no extra request", acc_cnt - a0, 1);
      chk(vld_cnt == v0 + 1, "R11 no extra response", vld_cnt - v0, 1);
      chk(collected == 64'hC3C3_0000_FFFF_0001, "R11 read data intact", collected,
          64'hC3C3_0000_FFFF_0001);

      // reset in the middle of a header, then a clean read, R12 R1
      send_word(64'h0);
      rx_vld = 1'b1;
      rx_dat = 1'b1;
      idle(1);
      rx_vld = 1'b0;
      idle(20);
      rst_n = 1'b0;
      idle(2);
      rx_dat = 1'b0;
      rst_n = 1'b1;
      idle(1);
      a0 = acc_cnt;
      rd_value = 64'h0000_0001_8000_0000;
      send_word({8'h81, 16'h0, 40'h80_0000_0000});
      idle(80);
      chk(acc_cnt == a0 + 1 && cap_addr == 40'h80_0000_0000, "R12 clean restart",
          cap_addr, 40'h80_0000_0000);
      chk(collected == 64'h0000_0001_8000_0000, "R1 frame after reset", collected,
          64'h0000_0001_8000_0000);
      chk(!err_flag, "R12 no error after restart", err_flag, 0);

      // data line idle outside read returns, R7
      chk(stray == 0, "R7 idle data line", stray, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule